// File: doc/BRIEF.md
# FP16 Operand Stack Controller

This block owns an eight-deep stack of 16-bit half-precision values and carries out the data movement of a stack-based floating-point unit. Each valid cycle it decodes one 5-bit operation code, a 3-bit operand selector and a swap bit. It presents the top-of-stack value and the selected deeper entry to an external combinational arithmetic port. In the same cycle it writes the returned result back into the stack. It also pushes and pops values, pushes constants, immediates and register-file values, and pops the top into the register file.

Every access is relative to the top of the stack. The top entry (depth 0) is always one operand. The selector picks depth n as the other operand. The swap bit exchanges the two operand roles and moves the result to the other slot. The stack is a circular buffer with a wrapping top pointer, so a ninth push overwrites the deepest entry. The arithmetic port receives a function code and returns its result in the same cycle. Two flags, zero and negative, describe the last value written back and feed an external flag register.

Top module: `fpstk_ctrl`

## Requirements
- R1: After reset the top pointer is 0, every entry reads 0x0000 and both flags are clear.
- R2: Entry depth n is the storage slot (top + n) mod 8. When op_swap is 0, ar_a carries depth 0 and ar_b carries depth op_sel. When op_swap is 1 on a two-operand code (0x01 to 0x0C), the two are exchanged. ar_fn is 1 for add (0x01 to 0x02), 2 for subtract (0x03 to 0x06), 3 for multiply (0x07 to 0x08), 4 for divide (0x09 to 0x0C), 5 for one-operand codes (0x0D to 0x13) and 0 for all other codes. ar_uop is the code minus 0x0D.
- R3: A two-operand code writes ar_res to depth 0, except the reversed codes 0x05, 0x06, 0x0B and 0x0C, which write to depth op_sel. op_swap set to 1 inverts that choice of destination.
- R4: The popping two-operand codes (even values 0x02 to 0x0C) pop after the write. Old depth k+1 becomes depth k, and old depth 0 becomes depth 7.
- R5: One-operand codes 0x0D to 0x13 write ar_res to depth 0 with ar_a equal to depth 0 regardless of op_swap, and leave the depth unchanged.
- R6: Code 0x15 pushes rf_rdata, with rf_addr equal to op_sel. Code 0x18 pushes op_imm. A push makes the value depth 0 and moves old depth k to k+1, overwriting old depth 7.
- R7: Code 0x17 pushes a constant chosen by op_sel from 0..7: 0x0000, 0x3C00, 0x4248, 0x409B, 0x3DC5, 0x34D1, 0x398C, 0x4170.
- R8: Code 0x16 drives rf_we=1, rf_addr=op_sel and rf_wdata=depth 0 in its cycle, then pops. rf_we is 0 for every other input.
- R9: Code 0x14 sets the flags from depth 0 and leaves the stack unchanged.
- R10: From the cycle after any writing, pushing or storing operation, flg_zero is 1 when bits 14:0 of the value written, pushed or stored are all 0, and flg_neg equals its bit 15.
- R11: Codes 0x00 and 0x19 to 0x1F, and any cycle with op_valid low, change neither the stack nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| op_sel | input | 3 | Stack depth, register index or constant index |
| op_swap | input | 1 | Exchange operand roles and destination |
| op_imm | input | 16 | Immediate value for code 0x18 |
| ar_a | output | 16 | First operand to the arithmetic port |
| ar_b | output | 16 | Second operand to the arithmetic port |
| ar_fn | output | 3 | Arithmetic function code |
| ar_uop | output | 3 | One-operand function index |
| ar_res | input | 16 | Combinational result from the arithmetic port |
| rf_addr | output | 3 | Shared register-file index |
| rf_rdata | input | 16 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 16 | Register-file write data |
| flg_zero | output | 1 | Last written value is zero |
| flg_neg | output | 1 | Last written value has its sign bit set |

## Verification
Operands, function codes and the register-file write strobe are combinational. They are due in the same cycle as the operation, so the bench samples them 1 ns after driving its inputs on the falling edge. Stack contents and flags change at the next rising edge. The bench reads them back after the following falling edge, using no-operation cycles and ar_b to reach each depth. The bench keeps its own shifting model of the stack and sweeps every two-operand code against every selector and swap value, with a known stack loaded before each case.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 8;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int OPC_W  = 5;

    localparam logic [OPC_W-1:0] OPC_NOP      = 5'h00;
    localparam logic [OPC_W-1:0] OPC_ADD      = 5'h01;
    localparam logic [OPC_W-1:0] OPC_ADDP_END = 5'h02;
    localparam logic [OPC_W-1:0] OPC_SUB_END  = 5'h06;
    localparam logic [OPC_W-1:0] OPC_MUL_END  = 5'h08;
    localparam logic [OPC_W-1:0] OPC_SUBR     = 5'h05;
    localparam logic [OPC_W-1:0] OPC_SUBRP    = 5'h06;
    localparam logic [OPC_W-1:0] OPC_DIVR     = 5'h0B;
    localparam logic [OPC_W-1:0] OPC_DIVRP    = 5'h0C;
    localparam logic [OPC_W-1:0] OPC_UN_FIRST = 5'h0D;
    localparam logic [OPC_W-1:0] OPC_UN_LAST  = 5'h13;
    localparam logic [OPC_W-1:0] OPC_FLAGS    = 5'h14;
    localparam logic [OPC_W-1:0] OPC_LOADR    = 5'h15;
    localparam logic [OPC_W-1:0] OPC_STORER   = 5'h16;
    localparam logic [OPC_W-1:0] OPC_CONST    = 5'h17;
    localparam logic [OPC_W-1:0] OPC_IMM      = 5'h18;

    typedef enum logic [2:0] {
        FN_NONE  = 3'd0,
        FN_ADD   = 3'd1,
        FN_SUB   = 3'd2,
        FN_MUL   = 3'd3,
        FN_DIV   = 3'd4,
        FN_UNARY = 3'd5
    } arfn_e;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_RF    = 2'd1,
        SRC_CONST = 2'd2,
        SRC_IMM   = 2'd3
    } wsrc_e;

    typedef struct packed {
        logic  dyad;      // two-operand arithmetic
        logic  rev;       // result goes to depth n before swap
        logic  push;
        logic  pop;
        logic  wr;        // in-place write (not push)
        logic  upd;       // flags are updated
        logic  flag_st0;  // flags come from depth 0, not write-back value
        logic  rf_we;
        wsrc_e src;
        arfn_e fn;
        logic [2:0] uop;
    } dec_t;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             f0;
        logic             fn;
    } ctl_t;
endpackage

// File: rtl/fpstk_dec.sv
module fpstk_dec
    import fpstk_pkg::*;
(
    input  logic             valid,
    input  logic [OPC_W-1:0] code,
    output dec_t             dec
);
    always_comb begin
        dec     = '0;
        dec.src = SRC_ARITH;
        dec.fn  = FN_NONE;
        if (valid) begin
            if (code >= OPC_ADD && code <= OPC_DIVRP) begin
                dec.dyad = 1'b1;
                dec.wr   = 1'b1;
                dec.upd  = 1'b1;
                dec.pop  = ~code[0];
                dec.rev  = (code == OPC_SUBR) || (code == OPC_SUBRP) ||
                           (code == OPC_DIVR) || (code == OPC_DIVRP);
                if (code <= OPC_ADDP_END)     dec.fn = FN_ADD;
                else if (code <= OPC_SUB_END) dec.fn = FN_SUB;
                else if (code <= OPC_MUL_END) dec.fn = FN_MUL;
                else                          dec.fn = FN_DIV;
            end else if (code >= OPC_UN_FIRST && code <= OPC_UN_LAST) begin
                dec.wr  = 1'b1;
                dec.upd = 1'b1;
                dec.fn  = FN_UNARY;
                dec.uop = code[2:0] - OPC_UN_FIRST[2:0];
            end else begin
                case (code)
                    OPC_FLAGS: begin
                        dec.upd      = 1'b1;
                        dec.flag_st0 = 1'b1;
                    end
                    OPC_LOADR: begin
                        dec.push = 1'b1;
                        dec.upd  = 1'b1;
                        dec.src  = SRC_RF;
                    end
                    OPC_CONST: begin
                        dec.push = 1'b1;
                        dec.upd  = 1'b1;
                        dec.src  = SRC_CONST;
                    end
                    OPC_IMM: begin
                        dec.push = 1'b1;
                        dec.upd  = 1'b1;
                        dec.src  = SRC_IMM;
                    end
                    OPC_STORER: begin
                        dec.rf_we    = 1'b1;
                        dec.pop      = 1'b1;
                        dec.upd      = 1'b1;
                        dec.flag_st0 = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fpstk_crom.sv
module fpstk_crom
    import fpstk_pkg::*;
(
    input  logic [2:0]        sel,
    output logic [DATA_W-1:0] val
);
    always_comb begin
        case (sel)
            3'd0:    val = 16'h0000; // zero
            3'd1:    val = 16'h3C00; // one
            3'd2:    val = 16'h4248; // pi
            3'd3:    val = 16'h409B; // natural log of ten
            3'd4:    val = 16'h3DC5; // base-2 log of e
            3'd5:    val = 16'h34D1; // base-10 log of two
            3'd6:    val = 16'h398C; // natural log of two
            default: val = 16'h4170; // e
        endcase
    end
endmodule

// File: rtl/fpstk_store.sv
module fpstk_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [DATA_W-1:0]        rdata_a,
    output logic [DATA_W-1:0]        rdata_b
);
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [PTR_W-1:0]  op_sel,
    input  logic              op_swap,
    input  logic [DATA_W-1:0] op_imm,
    output logic [DATA_W-1:0] ar_a,
    output logic [DATA_W-1:0] ar_b,
    output logic [2:0]        ar_fn,
    output logic [2:0]        ar_uop,
    input  logic [DATA_W-1:0] ar_res,
    output logic [PTR_W-1:0]  rf_addr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              flg_zero,
    output logic              flg_neg
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    dec_t              dec;
    ctl_t              ctl_d, ctl_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  idx_n;
    logic [DATA_W-1:0] st0, stn, cval, wb_val, flag_src;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;

    fpstk_dec i_dec (
        .valid (op_valid),
        .code  (op_code),
        .dec   (dec)
    );

    fpstk_crom i_crom (
        .sel (op_sel),
        .val (cval)
    );

    assign ptr_q = ctl_q.ptr;
    assign idx_n = ptr_q + op_sel;

    fpstk_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (wr_idx),
        .wdata   (wb_val),
        .raddr_a (ptr_q),
        .raddr_b (idx_n),
        .rdata_a (st0),
        .rdata_b (stn)
    );

    // Operand presentation: roles exchange only for two-operand codes.
    assign ar_a   = (dec.dyad && op_swap) ? stn : st0;
    assign ar_b   = (dec.dyad && op_swap) ? st0 : stn;
    assign ar_fn  = dec.fn;
    assign ar_uop = dec.uop;

    assign rf_addr  = op_sel;
    assign rf_we    = dec.rf_we;
    assign rf_wdata = st0;

    always_comb begin
        case (dec.src)
            SRC_RF:    wb_val = rf_rdata;
            SRC_CONST: wb_val = cval;
            SRC_IMM:   wb_val = op_imm;
            default:   wb_val = ar_res;
        endcase
    end

    assign flag_src = dec.flag_st0 ? st0 : wb_val;

    always_comb begin
        ctl_d  = ctl_q;
        wr_en  = 1'b0;
        wr_idx = ptr_q;
        if (dec.push) begin
            wr_en     = 1'b1;
            wr_idx    = ptr_q - PTR_ONE;
            ctl_d.ptr = ptr_q - PTR_ONE;
        end else if (dec.wr) begin
            wr_en  = 1'b1;
            wr_idx = (dec.dyad && (dec.rev ^ op_swap)) ? idx_n : ptr_q;
        end
        if (dec.pop) begin
            ctl_d.ptr = ptr_q + PTR_ONE;
        end
        if (dec.upd) begin
            ctl_d.f0 = ~|flag_src[DATA_W-2:0];
            ctl_d.fn = flag_src[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign flg_zero = ctl_q.f0;
    assign flg_neg  = ctl_q.fn;
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk
    import fpstk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [OPC_W-1:0] op_code,
    input logic             rf_we,
    input logic [PTR_W-1:0] ptr_q,
    input logic             flg_zero,
    input logic             flg_neg
);
    logic is_push, is_pop, is_quiet;
    assign is_push  = op_valid && (op_code == OPC_LOADR || op_code == OPC_CONST ||
                                   op_code == OPC_IMM);
    assign is_pop   = op_valid && (op_code == OPC_STORER ||
                      (op_code >= 5'h02 && op_code <= 5'h0C && !op_code[0]));
    assign is_quiet = !op_valid || op_code == OPC_NOP || op_code >= 5'h19;

    AST_PUSH_MOVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        is_push |=> ptr_q == $past(ptr_q) - PTR_W'(1)); // R6
    AST_POP_MOVES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        is_pop |=> ptr_q == $past(ptr_q) + PTR_W'(1)); // R4
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        is_quiet |=> $stable(ptr_q) && $stable(flg_zero) && $stable(flg_neg)); // R11
    AST_STORE_ONLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> op_valid && op_code == OPC_STORER); // R8
    AST_FLAGS_KEEP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OPC_FLAGS) |=> $stable(ptr_q)); // R9
endmodule

bind fpstk_ctrl fpstk_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .rf_we    (rf_we),
    .ptr_q    (ptr_q),
    .flg_zero (flg_zero),
    .flg_neg  (flg_neg)
);

// File: tb/test_fpstk_ctrl.sv
`timescale 1ns/1ps
module test_fpstk_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [2:0]  op_sel = '0;
    logic        op_swap = 1'b0;
    logic [15:0] op_imm = '0;
    logic [15:0] ar_a, ar_b, ar_res, rf_rdata, rf_wdata;
    logic [2:0]  ar_fn, ar_uop, rf_addr;
    logic        rf_we, flg_zero, flg_neg;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] m [8];
    logic ef0 = 1'b0, efn = 1'b0;

    always #10 clk = ~clk;

    fpstk_ctrl i_fpstk_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_sel(op_sel), .op_swap(op_swap), .op_imm(op_imm), .ar_a(ar_a),
        .ar_b(ar_b), .ar_fn(ar_fn), .ar_uop(ar_uop), .ar_res(ar_res),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .flg_zero(flg_zero), .flg_neg(flg_neg)
    );

    function automatic logic [15:0] calc(input logic [2:0] fn, input logic [2:0] u,
                                         input logic [15:0] a, input logic [15:0] b);
        case (fn)
            3'd1:    return a + b;
            3'd2:    return a - b;
            3'd3:    return a * b;
            3'd4:    return a ^ b;
            3'd5:    return ~a ^ {13'd0, u};
            default: return 16'hDEAD;
        endcase
    endfunction

    assign ar_res   = calc(ar_fn, ar_uop, ar_a, ar_b);
    assign rf_rdata = 16'h5A00 | {13'd0, rf_addr};

    function automatic logic [15:0] cst(input int k);
        case (k)
            0: return 16'h0000; 1: return 16'h3C00; 2: return 16'h4248;
            3: return 16'h409B; 4: return 16'h3DC5; 5: return 16'h34D1;
            6: return 16'h398C; default: return 16'h4170;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_push(input logic [15:0] v);
        for (int i = 7; i > 0; i--) m[i] = m[i-1];
        m[0] = v;
        ef0 = (v[14:0] == 15'd0); efn = v[15];
    endtask

    task automatic m_pop();
        logic [15:0] t;
        t = m[0];
        for (int i = 0; i < 7; i++) m[i] = m[i+1];
        m[7] = t;
    endtask

    // Reads every depth through ar_b with no-op cycles; stays in the low phase.
    task automatic check_all(input string req);
        op_valid = 1'b1; op_code = 5'h00; op_swap = 1'b0;
        for (int k = 0; k < 8; k++) begin
            op_sel = k[2:0];
            #1;
            chk(req, ar_b, m[k]);
        end
        chk(req, {15'd0, flg_zero}, {15'd0, ef0});
        chk(req, {15'd0, flg_neg},  {15'd0, efn});
        op_valid = 1'b0;
    endtask

    task automatic issue(input logic [4:0] c, input logic [2:0] s, input logic sw,
                         input logic [15:0] imm);
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_sel = s; op_swap = sw; op_imm = imm;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic load_stack(input int seed);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] v;
            v = 16'(seed * 16'h0137 + k * 16'h1111 + 1);
            if (k == 3) v = 16'h8000;
            issue(5'h18, 3'd0, 1'b0, v);
            m_push(v);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        for (int k = 0; k < 8; k++) m[k] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // Constant pushes for every selector
        for (int k = 0; k < 8; k++) begin
            issue(5'h17, k[2:0], 1'b0, 16'hFFFF);
            m_push(cst(k));
            check_all("R7");
        end

        // Register-file loads
        for (int k = 0; k < 8; k += 3) begin
            issue(5'h15, k[2:0], 1'b0, 16'h0);
            m_push(16'h5A00 | 16'(k));
            check_all("R6");
        end

        // Two-operand sweep over code, selector and swap
        for (int c = 1; c <= 12; c++) begin
            for (int n = 0; n < 8; n++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [15:0] ea, eb, r;
                    logic [2:0]  efn_code;
                    logic        rev, dn;
                    load_stack(c * 16 + n * 2 + s);
                    efn_code = (c <= 2) ? 3'd1 : (c <= 6) ? 3'd2 : (c <= 8) ? 3'd3 : 3'd4;
                    ea = s ? m[n] : m[0];
                    eb = s ? m[0] : m[n];
                    @(negedge clk);
                    op_valid = 1'b1; op_code = 5'(c); op_sel = 3'(n); op_swap = s[0];
                    #1;
                    chk("R2", ar_a, ea);
                    chk("R2", ar_b, eb);
                    chk("R2", {13'd0, ar_fn}, {13'd0, efn_code});
                    @(posedge clk);
                    @(negedge clk);
                    op_valid = 1'b0;
                    r   = calc(efn_code, 3'd0, ea, eb);
                    rev = (c == 5) || (c == 6) || (c == 11) || (c == 12);
                    dn  = rev ^ s[0];
                    if (dn) m[n] = r; else m[0] = r;
                    ef0 = (r[14:0] == 15'd0); efn = r[15];
                    if ((c % 2) == 0) begin
                        m_pop();
                        check_all("R4");
                    end else begin
                        check_all("R3");
                    end
                end
            end
        end

        // One-operand codes ignore swap and selector
        load_stack(7);
        for (int c = 13; c <= 19; c++) begin
            logic [15:0] r;
            @(negedge clk);
            op_valid = 1'b1; op_code = 5'(c); op_sel = 3'd3; op_swap = 1'b1;
            #1;
            chk("R5", ar_a, m[0]);
            chk("R2", {13'd0, ar_fn}, 16'd5);
            chk("R2", {13'd0, ar_uop}, 16'(c - 13));
            @(posedge clk);
            @(negedge clk);
            op_valid = 1'b0;
            r = calc(3'd5, 3'(c - 13), m[0], 16'h0);
            m[0] = r; ef0 = (r[14:0] == 15'd0); efn = r[15];
            check_all("R5");
        end

        // Flags from a store, then from depth 0 via the flag code (R9, R10)
        issue(5'h18, 3'd0, 1'b0, 16'h8000); m_push(16'h8000);
        check_all("R10");
        issue(5'h18, 3'd0, 1'b0, 16'h3C00); m_push(16'h3C00);
        check_all("R10");
        @(negedge clk);
        op_valid = 1'b1; op_code = 5'h16; op_sel = 3'd5; op_swap = 1'b0;
        #1;
        chk("R8", {15'd0, rf_we}, 16'd1);
        chk("R8", {13'd0, rf_addr}, 16'd5);
        chk("R8", rf_wdata, 16'h3C00);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk("R8", {15'd0, rf_we}, 16'd0);
        m_pop(); ef0 = 1'b0; efn = 1'b0;
        check_all("R8");
        issue(5'h14, 3'd2, 1'b1, 16'h0);
        ef0 = 1'b1; efn = 1'b1;
        check_all("R9");

        // Quiet codes and idle cycles
        issue(5'h18, 3'd0, 1'b0, 16'h4400); m_push(16'h4400);
        for (int c = 0; c < 32; c++) begin
            if (c == 0 || c >= 25) begin
                issue(5'(c), 3'(c), c[0], 16'h1234);
                @(negedge clk);
                #1;
                chk("R8", {15'd0, rf_we}, 16'd0);
                check_all("R11");
            end
        end
        @(negedge clk);
        op_valid = 1'b0; op_code = 5'h18; op_imm = 16'h0000;
        @(posedge clk);
        @(negedge clk);
        check_all("R11");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule